// File: doc/BRIEF.md
# Same-Page Translation Ordering Tracker

This block keeps in-flight address translation requests from walking the same page in parallel. A request that names a stream identifier, a substream identifier and an address registers with the tracker and receives a slot. Before its walk starts, the request's owner issues a hold query for that slot. The tracker grants the slot (`go`) only when no older live request carries the same page key. The page key is made from the stream identifier, the substream identifier and the address with its low 12 bits cleared.

A slot that is blocked waits. It is re-examined against older entries only after some entry has been removed. When the owner finishes, it releases the slot. That removes the entry, shifts the age ranks of the younger entries and wakes the waiters. A request whose byte span runs past the end of its 4 KiB page is refused with a fault and takes no slot. A release that names a slot holding no request sets a sticky error flag.

Top module: `otr_page_order`

## Requirements
- R1: After reset, `reg_ready` is 1 and `go`, `ack_valid` and `rel_err` are all 0.
- R2: An accepted registration for which the page offset `reg_addr[11:0]` plus `reg_size` is greater than 4096 returns `ack_valid`=1 with `ack_fault`=1 one cycle later and takes no slot. A sum of exactly 4096 is accepted with `ack_fault`=0.
- R3: A registration is accepted when `reg_valid` and `reg_ready` are both 1. One cycle later it returns `ack_valid`=1 with `ack_slot` set to the lowest-numbered free slot. When all 8 slots are live, `reg_ready` is 0 and `reg_valid` yields no acknowledge.
- R4: A hold query on a registered, unqueried slot with no older live entry of equal key raises `go` for that slot one cycle after the query.
- R5: Two entries have equal keys when `reg_sid`, `reg_ssid` and `reg_addr[47:12]` all match; the low 12 address bits play no part. A queried slot with an older live entry of equal key keeps `go` at 0, and no two slots with equal keys are granted at once.
- R6: An entry that differs from a queried slot in stream identifier, substream identifier or page does not block it.
- R7: A younger live entry of equal key never blocks an older slot's hold query.
- R8: When the last older equal-key entry of a waiting slot is released, that slot's `go` is still 0 in the cycle after the release and rises in the cycle after that.
- R9: A waiting slot with several older equal-key entries is granted only after every one of them has been released.
- R10: A release of a slot that holds no request sets `rel_err`, and `rel_err` stays 1 until reset. Releases of live slots leave it at 0.
- R11: A release clears `go` for that slot in the next cycle and returns the slot to the free pool, where later registrations can take it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Registration request |
| reg_ready | output | 1 | A free slot exists |
| reg_addr | input | 48 | Request address |
| reg_size | input | 13 | Request size in bytes |
| reg_sid | input | 8 | Stream identifier |
| reg_ssid | input | 8 | Substream identifier |
| ack_valid | output | 1 | Registration outcome valid (one-cycle pulse) |
| ack_slot | output | 3 | Slot assigned to the registration |
| ack_fault | output | 1 | Registration refused: the span leaves its page |
| hold_valid | input | 1 | Hold query |
| hold_slot | input | 3 | Slot being queried |
| rel_valid | input | 1 | Release request |
| rel_slot | input | 3 | Slot being released |
| go | output | 8 | Per-slot grant |
| rel_err | output | 1 | Sticky flag for a release of an empty slot |

## Verification
The checker assumes that the owner queries a slot only after that slot's acknowledge, and that it releases each slot once. It also assumes `hold_slot` and `rel_slot` are stable whenever their valid is high. The bench drives each stimulus at the falling edge and keeps it up for exactly one rising edge. Its only out-of-protocol act is the single deliberate release of an empty slot that exercises the error flag. The grant-uniqueness check takes the stored keys as given. That is why the stimulus always pairs colliding requests inside one stream and substream pair, and sets them against neighbours that differ in exactly one field.

// File: rtl/otr_pkg.sv
package otr_pkg;

    // Lifecycle of one tracker slot.
    typedef enum logic [1:0] {
        SL_FREE = 2'd0,   // no request held
        SL_IDLE = 2'd1,   // registered, no hold query yet
        SL_WAIT = 2'd2,   // queried, blocked by an older equal key
        SL_GO   = 2'd3    // granted
    } slot_phase_e;

endpackage

// File: rtl/otr_span_check.sv
module otr_span_check #(
    parameter int ADDR_W    = 48,
    parameter int SIZE_W    = 13,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              crosses
);
    localparam int SUM_W = ((SIZE_W > PAGE_BITS) ? SIZE_W : PAGE_BITS) + 1;

    logic [SUM_W-1:0] span_end;
    logic [SUM_W-1:0] page_len;

    always_comb begin
        span_end = SUM_W'(addr[PAGE_BITS-1:0]) + SUM_W'(size);
        page_len = SUM_W'(1) << PAGE_BITS;
        crosses  = (span_end > page_len);
    end
endmodule

// File: rtl/otr_slot_alloc.sv
module otr_slot_alloc #(
    parameter int N      = 8,
    parameter int SLOT_W = $clog2(N)
) (
    input  logic [N-1:0]      free_mask,
    output logic              found,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        found = |free_mask;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_mask[i]) idx = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/otr_key_match.sv
module otr_key_match #(
    parameter int N      = 8,
    parameter int KEY_W  = 52,
    parameter int RANK_W = 3
) (
    input  logic [N-1:0]             live,
    input  logic [N-1:0][KEY_W-1:0]  key,
    input  logic [N-1:0][RANK_W-1:0] rank,
    output logic [N-1:0]             blocked
);
    logic [N-1:0][N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_self
                assign hit[i][j] = 1'b0;
            end else begin : g_other
                // j blocks i when j is live, equal key and older (lower rank)
                assign hit[i][j] = live[j] && (key[j] == key[i]) && (rank[j] < rank[i]);
            end
        end
        assign blocked[i] = |hit[i];
    end
endmodule

// File: rtl/otr_page_order.sv
module otr_page_order #(
    parameter int N         = 8,
    parameter int ADDR_W    = 48,
    parameter int SID_W     = 8,
    parameter int SSID_W    = 8,
    parameter int SIZE_W    = 13,
    parameter int PAGE_BITS = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_valid,
    output logic                     reg_ready,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [SIZE_W-1:0]        reg_size,
    input  logic [SID_W-1:0]         reg_sid,
    input  logic [SSID_W-1:0]        reg_ssid,
    output logic                     ack_valid,
    output logic [$clog2(N)-1:0]     ack_slot,
    output logic                     ack_fault,
    input  logic                     hold_valid,
    input  logic [$clog2(N)-1:0]     hold_slot,
    input  logic                     rel_valid,
    input  logic [$clog2(N)-1:0]     rel_slot,
    output logic [N-1:0]             go,
    output logic                     rel_err
);
    import otr_pkg::*;

    localparam int SLOT_W = $clog2(N);
    localparam int RANK_W = $clog2(N);
    localparam int CNT_W  = SLOT_W + 1;
    localparam int KEY_W  = SID_W + SSID_W + ADDR_W - PAGE_BITS;

    typedef struct packed {
        slot_phase_e [N-1:0]       phase;
        logic [N-1:0][KEY_W-1:0]   key;
        logic [N-1:0][RANK_W-1:0]  rank;
        logic                      rm;
        logic                      ack_v;
        logic [SLOT_W-1:0]         ack_slot;
        logic                      ack_fault;
        logic                      err;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]       live;
    logic [N-1:0]       blocked;
    logic               free_found;
    logic [SLOT_W-1:0]  free_idx;
    logic               crosses;
    logic [KEY_W-1:0]   new_key;
    logic [CNT_W-1:0]   live_cnt;

    // signals brought out for the bound checker
    logic [N-1:0][KEY_W-1:0] keys_w;
    logic                    rm_w;

    for (genvar s = 0; s < N; s++) begin : g_live
        assign live[s] = (st_q.phase[s] != SL_FREE);
        assign go[s]   = (st_q.phase[s] == SL_GO);
    end

    assign new_key = {reg_sid, reg_ssid, reg_addr[ADDR_W-1:PAGE_BITS]};

    otr_span_check #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .PAGE_BITS(PAGE_BITS)
    ) u_span (
        .addr   (reg_addr),
        .size   (reg_size),
        .crosses(crosses)
    );

    otr_slot_alloc #(
        .N     (N),
        .SLOT_W(SLOT_W)
    ) u_alloc (
        .free_mask(~live),
        .found    (free_found),
        .idx      (free_idx)
    );

    otr_key_match #(
        .N     (N),
        .KEY_W (KEY_W),
        .RANK_W(RANK_W)
    ) u_match (
        .live   (live),
        .key    (st_q.key),
        .rank   (st_q.rank),
        .blocked(blocked)
    );

    assign reg_ready = free_found;

    always_comb begin
        live_cnt = '0;
        for (int k = 0; k < N; k++) begin
            live_cnt = live_cnt + CNT_W'(live[k]);
        end
    end

    always_comb begin
        logic hs;
        logic rel_hit;

        st_d           = st_q;
        st_d.rm        = 1'b0;
        st_d.ack_v     = 1'b0;
        st_d.ack_fault = 1'b0;

        hs      = reg_valid && free_found;
        rel_hit = rel_valid && live[rel_slot];

        // waiters re-scan older entries after a removal
        if (st_q.rm) begin
            for (int k = 0; k < N; k++) begin
                if (st_q.phase[k] == SL_WAIT && !blocked[k]) st_d.phase[k] = SL_GO;
            end
        end

        // hold query on a registered slot
        if (hold_valid && st_q.phase[hold_slot] == SL_IDLE) begin
            st_d.phase[hold_slot] = blocked[hold_slot] ? SL_WAIT : SL_GO;
        end

        // release: free the slot, close the rank gap, broadcast removal
        if (rel_valid) begin
            if (rel_hit) begin
                st_d.phase[rel_slot] = SL_FREE;
                st_d.rm              = 1'b1;
                for (int k = 0; k < N; k++) begin
                    if (live[k] && st_q.rank[k] > st_q.rank[rel_slot]) begin
                        st_d.rank[k] = st_q.rank[k] - RANK_W'(1);
                    end
                end
            end else begin
                st_d.err = 1'b1;
            end
        end

        // registration takes the lowest free slot as the youngest entry
        if (hs) begin
            st_d.ack_v     = 1'b1;
            st_d.ack_fault = crosses;
            st_d.ack_slot  = free_idx;
            if (!crosses) begin
                st_d.phase[free_idx] = SL_IDLE;
                st_d.key[free_idx]   = new_key;
                st_d.rank[free_idx]  = RANK_W'(live_cnt - CNT_W'(rel_hit));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_valid = st_q.ack_v;
    assign ack_slot  = st_q.ack_slot;
    assign ack_fault = st_q.ack_fault;
    assign rel_err   = st_q.err;
    assign keys_w    = st_q.key;
    assign rm_w      = st_q.rm;

endmodule

// File: rtl/otr_page_order_chk.sv
module otr_page_order_chk #(
    parameter int N      = 8,
    parameter int SLOT_W = 3,
    parameter int KEY_W  = 52
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_valid,
    input logic                    reg_ready,
    input logic                    ack_valid,
    input logic                    ack_fault,
    input logic                    hold_valid,
    input logic [SLOT_W-1:0]       hold_slot,
    input logic                    rel_valid,
    input logic [SLOT_W-1:0]       rel_slot,
    input logic [N-1:0]            go,
    input logic                    rel_err,
    input logic                    rm,
    input logic [N-1:0][KEY_W-1:0] keys
);
    assert_fault_has_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fault |-> ack_valid);

    assert_no_ack_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_ready) |=> !ack_valid);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |=> rel_err);

    assert_release_drops_go_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> !go[$past(rel_slot)]);

    for (genvar i = 0; i < N; i++) begin : g_slot
        // R4 / R8: a grant appears only after a query of this slot or a removal
        assert_go_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(go[i]) |-> (($past(hold_valid) && $past(hold_slot) == SLOT_W'(i)) || $past(rm)));

        for (genvar j = i + 1; j < N; j++) begin : g_pair
            assert_unique_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(go[i] && go[j] && keys[i] == keys[j]));
        end
    end
endmodule

bind otr_page_order otr_page_order_chk #(
    .N     (N),
    .SLOT_W(SLOT_W),
    .KEY_W (KEY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_ready (reg_ready),
    .ack_valid (ack_valid),
    .ack_fault (ack_fault),
    .hold_valid(hold_valid),
    .hold_slot (hold_slot),
    .rel_valid (rel_valid),
    .rel_slot  (rel_slot),
    .go        (go),
    .rel_err   (rel_err),
    .rm        (rm_w),
    .keys      (keys_w)
);

// File: tb/sim_otr_page_order.sv
module sim_otr_page_order;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_ready;
    logic [47:0] reg_addr = '0;
    logic [12:0] reg_size = '0;
    logic [7:0]  reg_sid = '0;
    logic [7:0]  reg_ssid = '0;
    logic        ack_valid;
    logic [2:0]  ack_slot;
    logic        ack_fault;
    logic        hold_valid = 1'b0;
    logic [2:0]  hold_slot = '0;
    logic        rel_valid = 1'b0;
    logic [2:0]  rel_slot = '0;
    logic [7:0]  go;
    logic        rel_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    otr_page_order u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_sid(reg_sid), .reg_ssid(reg_ssid),
        .ack_valid(ack_valid), .ack_slot(ack_slot), .ack_fault(ack_fault),
        .hold_valid(hold_valid), .hold_slot(hold_slot),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .go(go), .rel_err(rel_err)
    );

    typedef struct packed {
        logic [11:0] off;
        logic [12:0] size;
        logic        fault;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{12'h000, 13'd4096, 1'b0},
        '{12'h001, 13'd4096, 1'b1},
        '{12'hFFF, 13'd1,    1'b0},
        '{12'hFFF, 13'd2,    1'b1},
        '{12'h800, 13'd2048, 1'b0},
        '{12'h800, 13'd2049, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reg(input logic [47:0] a, input logic [12:0] sz,
                          input logic [7:0] s, input logic [7:0] ss);
        reg_addr = a; reg_size = sz; reg_sid = s; reg_ssid = ss; reg_valid = 1'b1;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic do_hold(input logic [2:0] sl);
        hold_slot = sl; hold_valid = 1'b1;
        @(negedge clk);
        hold_valid = 1'b0;
    endtask

    task automatic do_rel(input logic [2:0] sl);
        rel_slot = sl; rel_valid = 1'b1;
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic reg_expect(input logic [47:0] a, input logic [7:0] s, input logic [7:0] ss,
                              input logic [2:0] exp_slot, input string tag);
        do_reg(a, 13'd4, s, ss);
        chk(ack_valid && !ack_fault && ack_slot == exp_slot, tag, ack_slot, exp_slot);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(reg_ready && go == 8'h00 && !ack_valid && !rel_err, "R1 reset state",
            {reg_ready, go, ack_valid, rel_err}, {1'b1, 8'h00, 1'b0, 1'b0});

        // R2 / R3 page-span vectors, each on an empty table
        foreach (VECS[v]) begin
            do_reg({36'h5, VECS[v].off}, VECS[v].size, 8'(v), 8'h0);
            chk(ack_valid && ack_fault == VECS[v].fault, "R2 span fault",
                ack_fault, VECS[v].fault);
            if (!VECS[v].fault) begin
                chk(ack_slot == 3'd0, "R3 lowest free slot", ack_slot, 0);
                do_rel(3'd0);
            end
        end
        idle(1);

        // R4 no older match: go one cycle after the query
        reg_expect(48'h10000, 8'd1, 8'd0, 3'd0, "R3 slot0");
        do_hold(3'd0);
        chk(go[0], "R4 go after hold", go[0], 1);

        // R5 older equal key blocks
        reg_expect(48'h10040, 8'd1, 8'd0, 3'd1, "R3 slot1");
        do_hold(3'd1);
        chk(!go[1], "R5 blocked by older", go[1], 0);
        idle(2);
        chk(!go[1], "R5 still blocked", go[1], 0);

        // R6 one differing field does not block
        reg_expect(48'h10000, 8'd2, 8'd0, 3'd2, "R3 slot2");
        do_hold(3'd2);
        chk(go[2], "R6 other sid", go[2], 1);
        reg_expect(48'h10000, 8'd1, 8'd3, 3'd3, "R3 slot3");
        do_hold(3'd3);
        chk(go[3], "R6 other ssid", go[3], 1);
        reg_expect(48'h11000, 8'd1, 8'd0, 3'd4, "R3 slot4");
        do_hold(3'd4);
        chk(go[4], "R6 other page", go[4], 1);

        // R5 low address bits ignored in the key
        reg_expect(48'h10ABC, 8'd1, 8'd0, 3'd5, "R3 slot5");
        do_hold(3'd5);
        chk(!go[5], "R5 low bits masked", go[5], 0);

        // R7 younger equal key does not block an older query
        reg_expect(48'h20000, 8'd4, 8'd1, 3'd6, "R3 slot6");
        reg_expect(48'h20800, 8'd4, 8'd1, 3'd7, "R3 slot7");
        chk(!reg_ready, "R3 full stalls", reg_ready, 0);
        do_reg(48'h30000, 13'd4, 8'd9, 8'd9);
        chk(!ack_valid, "R3 no ack when full", ack_valid, 0);
        do_hold(3'd7);
        chk(!go[7], "R7 young waits", go[7], 0);
        do_hold(3'd6);
        chk(go[6], "R7 older not blocked by younger", go[6], 1);

        // R8 / R9 / R11 releases wake waiters in order
        do_rel(3'd0);
        chk(!go[0], "R11 go dropped", go[0], 0);
        chk(!go[1], "R8 not yet", go[1], 0);
        idle(1);
        chk(go[1], "R8 wake after release", go[1], 1);
        chk(!go[5], "R9 second older remains", go[5], 0);
        do_rel(3'd1);
        idle(1);
        chk(go[5], "R9 wake after all older gone", go[5], 1);
        do_rel(3'd6);
        idle(1);
        chk(go[7], "R8 younger woken", go[7], 1);
        chk(!rel_err, "R10 no error on live releases", rel_err, 0);

        // R11 slot reuse
        chk(reg_ready, "R11 ready after release", reg_ready, 1);
        reg_expect(48'h40000, 8'd7, 8'd7, 3'd0, "R11 slot reused");

        // R10 release of an empty slot is sticky
        do_rel(3'd1);
        chk(rel_err, "R10 error raised", rel_err, 1);
        do_rel(3'd0);
        idle(2);
        chk(rel_err, "R10 error sticky", rel_err, 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule